// File: doc/BRIEF.md
# Zero-Crossing Gain Fade-Out Controller

This block owns a digital programmable-gain code and, on a software request, walks that code down to the mute code (zero). It sits next to an automatic level-control loop and shares the gain code with it. The attack and recovery algorithm of that loop is not part of this block. While the level loop runs, the gain is held here until a fade or an exit rule changes it.

Gain moves only on a signal zero crossing, so each step is inaudible. The total fade length is still fixed. The fade is cut into a set number of intervals. The gain takes one step in each interval: at the first zero crossing in that interval, or at the interval's end if no crossing arrives first. The fade always ends on the last interval boundary, and the gain is then forced to mute. Limiter requests during the fade remove extra codes but do not move that end point.

Leaving the fade follows one of two rules. Dropping only the request while level control stays on hands the loop the preset gain. Dropping both in the same cycle freezes the gain where it stands. Software may write the gain only while neither the fade nor level control is active.

Top module: `gfade_ctrl`

## Requirements
- R1: A fade starts only on a 0-to-1 change of `fade_req` seen in a non-fading state. The gain code does not move before that change, and holding the request high never restarts a fade.
- R2: During a fade the gain changes only on a cycle with `smp_valid` high. Each interval removes one step: at the first zero crossing in that interval, or at the interval's last strobe if no crossing came first. A crossing that finds no pending step leaves the gain unchanged.
- R3: Interval length is `(4 << ivl_sel) * SMP_PER_MS` strobes, latched at fade start (`ivl_sel` 0/1/2/3 gives 4/8/16/32 ms). The step is 1 code when `step_sel`=0 and 2 codes when `step_sel`=1, also latched. The fade has `FADE_SPAN/step` intervals, so it lasts `FADE_SPAN*interval/step` strobes. After k intervals the gain is max(0, start − k·step), and after the last interval it is 0.
- R4: A zero crossing is a strobe whose sample (two's complement, sign in the top bit) is exactly zero, or whose sign bit differs from the previous strobe's sample. Zero counts as non-negative.
- R5: A strobe that is a zero crossing with `lim_req` high during a fade removes one extra step, clamped at 0. The fade still ends on the same strobe.
- R6: When the fade completes, `fade_done` rises and the gain stays 0 for as long as `fade_req` stays 1.
- R7: If `fade_req` falls during or after a fade while `lvl_en` is 1, the gain becomes `preset_gain` on the next edge and the fade ends.
- R8: If `fade_req` and `lvl_en` are both 0 during or after a fade, the fade ends and the gain keeps its current code.
- R9: A software write (`sw_wr`) loads `sw_gain` only when not fading and both `fade_req` and `lvl_en` are 0. Otherwise the write is ignored.
- R10: After reset the gain is `INIT_GAIN`, `fade_done` is 0 and no fade is running.
- R11: `muted` is 1 exactly when the gain code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Signed audio sample |
| fade_req | input | 1 | Fade-out request |
| lvl_en | input | 1 | Level-control enable |
| ivl_sel | input | 2 | Fade interval select |
| step_sel | input | 1 | Step size select (1 or 2 codes) |
| lim_req | input | 1 | Limiter reduction request |
| preset_gain | input | GW | Gain handed to level control on exit |
| sw_wr | input | 1 | Software gain write strobe |
| sw_gain | input | GW | Software gain value |
| gain | output | GW | Current gain code |
| muted | output | 1 | Gain is at the mute code |
| fade_done | output | 1 | Fade finished and mute held |

## Verification
The assertions assume `fade_req` and `lvl_en` change only as register writes would change them, and that `preset_gain` is stable in the cycle an exit happens. They also assume the sample data is meaningful only on strobe cycles. The bench drives every input just after a clock edge and keeps the strobe high on every cycle, so each interval boundary falls on a known cycle. Random fades draw the interval, step, start gain and sample signs from a seeded generator. Samples are never zero there, and the limiter stays off, so the gain expected at each interval boundary follows from the start gain alone.

// File: rtl/gfade_ctrl.sv
module gfade_ctrl #(
  parameter int DW          = 16,
  parameter int GW          = 8,
  parameter int SMP_PER_MS  = 48,
  parameter int FADE_SPAN   = 96,
  parameter int INIT_GAIN   = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          fade_req,
  input  logic          lvl_en,
  input  logic [1:0]    ivl_sel,
  input  logic          step_sel,
  input  logic          lim_req,
  input  logic [GW-1:0] preset_gain,
  input  logic          sw_wr,
  input  logic [GW-1:0] sw_gain,
  output logic [GW-1:0] gain,
  output logic          muted,
  output logic          fade_done
);

  localparam int TW = $clog2(32*SMP_PER_MS + 1);
  localparam int NW = $clog2(FADE_SPAN + 1);

  typedef enum logic [1:0] {S_IDLE, S_FADE, S_DONE} st_t;

  st_t           st;
  logic          req_q;
  logic          prev_neg;
  logic          pend;
  logic [1:0]    ivl_q;
  logic          stp_q;
  logic [TW-1:0] tcnt;
  logic [NW-1:0] icnt;
  logic [GW-1:0] gain_q;

  wire           cur_neg  = smp_data[DW-1];
  wire           zc       = smp_valid && ((smp_data == '0) || (cur_neg != prev_neg));
  wire           req_rise = fade_req && !req_q;

  logic [TW-1:0] ivl_last;
  logic [NW-1:0] n_last;
  logic [GW:0]   stepw;
  logic [GW:0]   dec;
  logic [GW-1:0] gain_dec;

  assign ivl_last = (TW'(4*SMP_PER_MS) << ivl_q) - TW'(1);
  assign n_last   = stp_q ? NW'(FADE_SPAN/2 - 1) : NW'(FADE_SPAN - 1);
  assign stepw    = stp_q ? (GW+1)'(2) : (GW+1)'(1);

  wire tout  = smp_valid && (tcnt == ivl_last);
  wire apply = pend && (zc || tout);
  wire lim   = zc && lim_req;

  assign dec      = (apply ? stepw : '0) + (lim ? stepw : '0);
  assign gain_dec = ({1'b0, gain_q} > dec) ? gain_q - dec[GW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      req_q    <= 1'b0;
      prev_neg <= 1'b0;
      pend     <= 1'b0;
      ivl_q    <= '0;
      stp_q    <= 1'b0;
      tcnt     <= '0;
      icnt     <= '0;
      gain_q   <= GW'(INIT_GAIN);
    end else begin
      req_q <= fade_req;
      if (smp_valid) prev_neg <= cur_neg;
      case (st)
        S_IDLE: begin
          if (req_rise) begin
            st    <= S_FADE;
            tcnt  <= '0;
            icnt  <= '0;
            pend  <= 1'b1;
            ivl_q <= ivl_sel;
            stp_q <= step_sel;
          end else if (sw_wr && !lvl_en && !fade_req) begin
            gain_q <= sw_gain;
          end
        end
        S_FADE: begin
          if (!fade_req) begin
            st   <= S_IDLE;
            pend <= 1'b0;
            if (lvl_en) gain_q <= preset_gain;
          end else if (smp_valid) begin
            gain_q <= gain_dec;
            if (tout) begin
              tcnt <= '0;
              if (icnt == n_last) begin
                st     <= S_DONE;
                gain_q <= '0;
                pend   <= 1'b0;
              end else begin
                icnt <= icnt + NW'(1);
                pend <= 1'b1;
              end
            end else begin
              tcnt <= tcnt + TW'(1);
              if (apply) pend <= 1'b0;
            end
          end
        end
        S_DONE: begin
          if (!fade_req) begin
            st <= S_IDLE;
            if (lvl_en) gain_q <= preset_gain;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gain      = gain_q;
  assign muted     = (gain_q == '0);
  assign fade_done = (st == S_DONE);

  AST_DONE_IS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    fade_done |-> muted);  // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_done && fade_req) |=> (fade_done && gain == '0));  // R6
  AST_NO_STROBE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FADE && fade_req && !smp_valid) |=> $stable(gain));  // R2
  AST_FADE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FADE && fade_req) |=> (gain <= $past(gain)));  // R2
  AST_EXIT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !fade_req && lvl_en) |=> (gain == $past(preset_gain) && !fade_done));  // R7
  AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !fade_req && !lvl_en) |=> ($stable(gain) && !fade_done));  // R8
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && lvl_en) |=> $stable(gain));  // R9

endmodule

// File: tb/gfade_ctrl_tb.sv
module gfade_ctrl_tb;
  localparam int DW = 16, GW = 8, SPM = 1, SPAN = 8, IG = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, fade_req = 1'b0, lvl_en = 1'b0, step_sel = 1'b0;
  logic lim_req = 1'b0, sw_wr = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [1:0]    ivl_sel = '0;
  logic [GW-1:0] preset_gain = '0, sw_gain = '0;
  logic [GW-1:0] gain;
  logic muted, fade_done;

  int n_chk = 0, n_bad = 0, cyc = 0;

  gfade_ctrl #(.DW(DW), .GW(GW), .SMP_PER_MS(SPM), .FADE_SPAN(SPAN), .INIT_GAIN(IG)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .fade_req(fade_req), .lvl_en(lvl_en), .ivl_sel(ivl_sel), .step_sel(step_sel),
    .lim_req(lim_req), .preset_gain(preset_gain), .sw_wr(sw_wr), .sw_gain(sw_gain),
    .gain(gain), .muted(muted), .fade_done(fade_done));

  always #5 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int s);
    smp_data = DW'(s);
    @(posedge clk); #1;
  endtask

  function automatic int ilen(int sel);
    return (4 * SPM) << sel;
  endfunction

  function automatic int exp_gain(int g0, int k, int st);
    int v = g0 - k * st;
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int rnd_smp();
    int mag = int'($urandom_range(1, 3000));
    return ($urandom_range(0, 1) == 1) ? -mag : mag;
  endfunction

  task automatic set_gain(int g);
    fade_req = 0; lvl_en = 0; sw_wr = 1; sw_gain = GW'(g);
    tick(100);
    sw_wr = 0;
  endtask

  task automatic start_fade(int sel, int stp);
    ivl_sel = 2'(sel); step_sel = 1'(stp); lvl_en = 1;
    tick(100); tick(100);
    fade_req = 1;
    tick(100);
  endtask

  task automatic run_fade(int g0, int sel, int stp, bit rnd);
    int L, N, st;
    set_gain(g0);
    start_fade(sel, stp);
    L = ilen(sel); st = stp + 1; N = SPAN / st;
    for (int k = 1; k <= N; k++) begin
      for (int j = 1; j <= L; j++) begin
        tick(rnd ? rnd_smp() : 100);
        if (!rnd && j == L - 1) check("R2 no step before timeout", int'(gain), exp_gain(g0, k - 1, st));
        if (j == L - 1 && k == N) check("R3 not done early", int'(fade_done), 0);
        if (j == L) check("R3 gain at interval end", int'(gain), (k == N) ? 0 : exp_gain(g0, k, st));
      end
    end
    check("R6 done at end", int'(fade_done), 1);
    check("R11 muted at end", int'(muted), 1);
    fade_req = 0; lvl_en = 0;
    tick(100);
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick(100); tick(100);
    rst_n = 1;
    smp_valid = 1;
    tick(100);
    check("R10 reset gain", int'(gain), IG);
    check("R10 reset done", int'(fade_done), 0);
    check("R11 reset muted", int'(muted), 0);

    // R1: strobes without a rising request leave the gain alone
    lvl_en = 1;
    for (int i = 0; i < 5; i++) tick(i[0] ? -50 : 50);
    check("R1 no fade without request edge", int'(gain), IG);

    // R9: write blocked while level control on, accepted when both off
    sw_wr = 1; sw_gain = 8'd77; tick(100); sw_wr = 0;
    check("R9 write ignored with lvl_en", int'(gain), IG);
    set_gain(40);
    check("R9 write accepted", int'(gain), 40);

    // Directed: crossings, zero sample, limiter, fixed end time
    start_fade(1, 1);
    tick(50);  check("R2 no crossing no step", int'(gain), 40);
    tick(60);  check("R2 still no step", int'(gain), 40);
    tick(-5);  check("R4 sign change steps", int'(gain), 38);
    tick(-7);  check("R2 one step per interval", int'(gain), 38);
    tick(-9);
    tick(0);   check("R2 crossing without pending step", int'(gain), 38);
    tick(3);
    tick(4);   check("R3 interval 1 end", int'(gain), 38);
    tick(0);   check("R4 zero sample is crossing", int'(gain), 36);
    tick(5);
    lim_req = 1;
    tick(-5);  check("R5 limiter removes extra step", int'(gain), 34);
    lim_req = 0;
    for (int i = 0; i < 5; i++) tick(-5);
    check("R5 interval 2 end", int'(gain), 34);
    for (int i = 0; i < 8; i++) tick(-1);
    check("R2 timeout step", int'(gain), 32);
    for (int i = 0; i < 7; i++) tick(-1);
    check("R5 end not moved early", int'(fade_done), 0);
    tick(-1);
    check("R5 done on fixed strobe", int'(fade_done), 1);
    check("R3 forced mute", int'(gain), 0);
    for (int i = 0; i < 6; i++) tick(i[0] ? 9 : -9);
    check("R6 mute held while requested", int'(gain), 0);
    check("R1 no restart while held", int'(fade_done), 1);
    preset_gain = 8'd70; fade_req = 0;
    tick(100);
    check("R7 preset after done", int'(gain), 70);
    check("R7 done cleared", int'(fade_done), 0);

    // R7: mid-fade release with level control on
    start_fade(0, 0);
    for (int i = 0; i < 5; i++) tick(100);
    check("R2 first step at timeout", int'(gain), 69);
    preset_gain = 8'd55; fade_req = 0;
    tick(100);
    check("R7 preset mid-fade", int'(gain), 55);

    // R8: both dropped together hold current code
    start_fade(0, 0);
    sw_wr = 1; sw_gain = 8'd9;
    tick(100);
    sw_wr = 0;
    check("R9 write ignored during fade", int'(gain), 55);
    for (int i = 0; i < 5; i++) tick(100);
    check("R3 one step after one interval", int'(gain), 54);
    fade_req = 0; lvl_en = 0;
    tick(100);
    for (int i = 0; i < 10; i++) tick(i[0] ? -100 : 100);
    check("R8 gain held", int'(gain), 54);
    check("R8 not done", int'(fade_done), 0);

    // Constant-sign fades over every interval code and step size
    for (int s = 0; s < 4; s++) run_fade(30 + s, s, s & 1, 1'b0);

    // Random fades
    for (int r = 0; r < 6; r++)
      run_fade(int'($urandom_range(3, 120)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 1)), 1'b1);

    summary();
  end
endmodule